// File: doc/BRIEF.md
# Eight-Lane Vector Multiply-Accumulate Unit

This block is a small arithmetic coprocessor for a narrow datapath. A host feeds it operand pairs one at a time; each pair lands in the next free slot of an eight-entry buffer. A fire command multiplies every buffered pair in the same cycle, adds the eight signed products through a single adder tree, and adds that sum into a persistent 32-bit accumulator.

The host side is only eight bits wide, so each fire also names which byte of the updated accumulator comes back. Software recovers the full 32-bit value by issuing several fires, the later ones with no new pairs so that they add zero. A clear input zeroes the accumulator and empties the buffer.

Top module: `vmac_top`

## Requirements
- R1: After reset `res_o` is 0, `res_vld_o` is 0, the accumulator is 0 and the buffer holds no pairs.
- R2: A push (`push_i` high, `fire_i` and `clear_i` low) stores `opa_i`/`opb_i` as a signed two's-complement pair in the slot the write pointer names, then advances the pointer.
- R3: A fire adds the sum of the signed products of all filled slots into the 32-bit accumulator. Unfilled slots contribute zero, and the accumulator wraps modulo 2^32.
- R4: On the clock edge that takes a fire, `res_o` becomes bits `[8*sel_i+7 : 8*sel_i]` of the updated accumulator (sel 0 = bits 7:0, sel 3 = bits 31:24). `res_vld_o` is high for exactly that one cycle per fire.
- R5: The write pointer wraps after eight pushes, so a ninth push overwrites slot 0.
- R6: A fire empties the buffer and resets the pointer; a following fire with no pushes adds zero.
- R7: `clear_i` zeroes the accumulator and empties the buffer. It takes priority over fire and push and raises no valid pulse.
- R8: A push in the same cycle as a fire is dropped. It does not reach the sum of that fire or of any later one.
- R9: The accumulator keeps its value between fires and sums across them until a clear.
- R10: `res_o` holds its last value in every cycle without an accepted fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Store one operand pair |
| opa_i | input | 8 | First operand, signed |
| opb_i | input | 8 | Second operand, signed |
| fire_i | input | 1 | Multiply, sum and accumulate |
| sel_i | input | 2 | Byte of the accumulator returned by a fire |
| clear_i | input | 1 | Zero the accumulator and empty the buffer |
| res_o | output | 8 | Selected result byte |
| res_vld_o | output | 1 | One-cycle pulse after each accepted fire |

## Verification
Properties check on every cycle that each accepted fire produces exactly one valid pulse, and that the accumulator and result byte stay put without a fire. They also check that clear zeroes the accumulator, that a fire empties the buffer, and that the pointer wraps. The arithmetic can only be shown by the bench's scenarios, which compare against a behavioural model: signed products, zero-weight empty slots, 32-bit wrap, byte selection, overwrite after eight pushes, and dropped pushes during a fire.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_PUSH  = 2'd1,
      CMD_FIRE  = 2'd2,
      CMD_CLEAR = 2'd3
   } vmac_cmd_e;

   function automatic vmac_cmd_e decode_cmd(input logic push, input logic fire, input logic clr);
      if (clr)       return CMD_CLEAR;
      else if (fire) return CMD_FIRE;
      else if (push) return CMD_PUSH;
      else           return CMD_IDLE;
   endfunction
endpackage

// File: rtl/vmac_opbuf.sv
module vmac_opbuf
   import vmac_pkg::*;
#(
   parameter int LANES = 8,
   parameter int OPW   = 8,
   localparam int PW   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  vmac_cmd_e                  cmd,
   input  logic [OPW-1:0]             opa,
   input  logic [OPW-1:0]             opb,
   output logic [LANES-1:0][OPW-1:0]  a_o,
   output logic [LANES-1:0][OPW-1:0]  b_o
);
   logic [LANES-1:0][OPW-1:0] a_q, b_q;
   logic [LANES-1:0]          fill_q;
   logic [PW-1:0]             ptr_q;
   logic [PW-1:0]             ptr_nxt;

   assign ptr_nxt = (ptr_q == PW'(LANES-1)) ? '0 : ptr_q + PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         fill_q <= '0;
         ptr_q  <= '0;
      end else begin
         case (cmd)
            CMD_PUSH: begin
               a_q[ptr_q]    <= opa;
               b_q[ptr_q]    <= opb;
               fill_q[ptr_q] <= 1'b1;
               ptr_q         <= ptr_nxt;
            end
            CMD_FIRE, CMD_CLEAR: begin
               fill_q <= '0;
               ptr_q  <= '0;
            end
            default: ;
         endcase
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_mask
      assign a_o[g] = fill_q[g] ? a_q[g] : '0;
      assign b_o[g] = fill_q[g] ? b_q[g] : '0;
   end

   // R5: pointer returns to slot 0 after the last slot is written
   a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PUSH && ptr_q == PW'(LANES-1)) |=> (ptr_q == '0));
   // R6, R7: fire or clear leaves an empty buffer
   a_r6_fire_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_FIRE || cmd == CMD_CLEAR) |=> (fill_q == '0 && ptr_q == '0));
   // R2: a push marks the slot it wrote as filled
   a_r2_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PUSH) |=> fill_q[$past(ptr_q)]);
endmodule

// File: rtl/vmac_tree.sv
module vmac_tree #(
   parameter int LANES = 8,
   parameter int OPW   = 8,
   localparam int PRW  = 2 * OPW,
   localparam int SUMW = PRW + $clog2(LANES)
) (
   input  logic [LANES-1:0][OPW-1:0] a_i,
   input  logic [LANES-1:0][OPW-1:0] b_i,
   output logic signed [SUMW-1:0]    sum_o
);
   logic signed [PRW-1:0]  prod [LANES];
   logic signed [SUMW-1:0] ext  [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_mul
      assign prod[g] = $signed(a_i[g]) * $signed(b_i[g]);
      assign ext[g]  = {{(SUMW-PRW){prod[g][PRW-1]}}, prod[g]};
   end

   always_comb begin
      sum_o = '0;
      for (int i = 0; i < LANES; i++) sum_o = sum_o + ext[i];
   end
endmodule

// File: rtl/vmac_slice.sv
module vmac_slice #(
   parameter int ACCW = 32,
   parameter int RESW = 8,
   localparam int NSL = ACCW / RESW,
   localparam int SW  = (NSL > 1) ? $clog2(NSL) : 1
) (
   input  logic [ACCW-1:0] word_i,
   input  logic [SW-1:0]   sel_i,
   output logic [RESW-1:0] part_o
);
   if (NSL == 1) begin : g_pass
      assign part_o = word_i[RESW-1:0];
   end else begin : g_mux
      logic [RESW-1:0] parts [NSL];
      for (genvar g = 0; g < NSL; g++) begin : g_part
         assign parts[g] = word_i[g*RESW +: RESW];
      end
      always_comb begin
         part_o = parts[0];
         for (int i = 0; i < NSL; i++)
            if (sel_i == SW'(i)) part_o = parts[i];
      end
   end
endmodule

// File: rtl/vmac_top.sv
module vmac_top
   import vmac_pkg::*;
#(
   parameter int LANES = 8,
   parameter int OPW   = 8,
   parameter int ACCW  = 32,
   parameter int RESW  = 8,
   localparam int NSL  = ACCW / RESW,
   localparam int SW   = (NSL > 1) ? $clog2(NSL) : 1,
   localparam int SUMW = 2 * OPW + $clog2(LANES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push_i,
   input  logic [OPW-1:0]  opa_i,
   input  logic [OPW-1:0]  opb_i,
   input  logic            fire_i,
   input  logic [SW-1:0]   sel_i,
   input  logic            clear_i,
   output logic [RESW-1:0] res_o,
   output logic            res_vld_o
);
   if (LANES < 2)          begin : g_chk_lanes $error("LANES must be at least 2"); end
   if (ACCW % RESW != 0)   begin : g_chk_div   $error("ACCW must be a multiple of RESW"); end
   if (ACCW < SUMW)        begin : g_chk_acc   $error("ACCW narrower than the product sum"); end

   vmac_cmd_e cmd;
   assign cmd = decode_cmd(push_i, fire_i, clear_i);

   logic [LANES-1:0][OPW-1:0] a_v, b_v;
   logic signed [SUMW-1:0]    sum;
   logic [ACCW-1:0]           acc_q, acc_nxt;
   logic [RESW-1:0]           part;

   vmac_opbuf #(.LANES(LANES), .OPW(OPW)) u_buf (
      .clk(clk), .rst_n(rst_n), .cmd(cmd),
      .opa(opa_i), .opb(opb_i), .a_o(a_v), .b_o(b_v)
   );

   vmac_tree #(.LANES(LANES), .OPW(OPW)) u_tree (
      .a_i(a_v), .b_i(b_v), .sum_o(sum)
   );

   assign acc_nxt = acc_q + {{(ACCW-SUMW){sum[SUMW-1]}}, sum};

   vmac_slice #(.ACCW(ACCW), .RESW(RESW)) u_slice (
      .word_i(acc_nxt), .sel_i(sel_i), .part_o(part)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= '0;
         res_o     <= '0;
         res_vld_o <= 1'b0;
      end else begin
         res_vld_o <= (cmd == CMD_FIRE);
         if (cmd == CMD_CLEAR) begin
            acc_q <= '0;
         end else if (cmd == CMD_FIRE) begin
            acc_q <= acc_nxt;
            res_o <= part;
         end
      end
   end

   // R4: every accepted fire gives a valid pulse on the next cycle
   a_r4_vld_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_i && !clear_i) |=> res_vld_o);
   // R4, R7: no pulse without an accepted fire
   a_r4_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
      !(fire_i && !clear_i) |=> !res_vld_o);
   // R7: clear zeroes the accumulator
   a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (acc_q == '0));
   // R9: accumulator holds between fires
   a_r9_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!fire_i && !clear_i) |=> $stable(acc_q));
   // R10: result byte holds without an accepted fire
   a_r10_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(fire_i && !clear_i) |=> $stable(res_o));
endmodule

// File: tb/tb_vmac_top.sv
module tb_vmac_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push_i = 1'b0, fire_i = 1'b0, clear_i = 1'b0;
   logic [7:0] opa_i = '0, opb_i = '0;
   logic [1:0] sel_i = '0;
   logic [7:0] res_o;
   logic       res_vld_o;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   // behavioural reference state
   int          m_a [8];
   int          m_b [8];
   bit          m_fill [8];
   int          m_ptr = 0;
   bit [31:0]   m_acc = '0;
   bit [7:0]    m_res = '0;
   bit          m_vld = 1'b0;

   always #10 clk = ~clk;

   vmac_top dut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .opa_i(opa_i), .opb_i(opb_i),
      .fire_i(fire_i), .sel_i(sel_i), .clear_i(clear_i),
      .res_o(res_o), .res_vld_o(res_vld_o)
   );

   task automatic model_reset();
      for (int i = 0; i < 8; i++) begin m_a[i] = 0; m_b[i] = 0; m_fill[i] = 0; end
      m_ptr = 0; m_acc = '0; m_res = '0; m_vld = 1'b0;
   endtask

   task automatic check(string req, logic [7:0] got_r, bit got_v);
      n_run++;
      if (got_v !== m_vld) begin
         n_fail++;
         $display("FAIL %s res_vld_o got %0b expected %0b", req, got_v, m_vld);
      end
      n_run++;
      if (got_r !== m_res) begin
         n_fail++;
         $display("FAIL %s res_o got %02h expected %02h", req, got_r, m_res);
      end
   endtask

   // one clock: drive at negedge, update model at posedge, compare at next negedge
   task automatic step(string req, bit p, int a, int b, bit f, int s, bit c);
      push_i = p; opa_i = 8'(a); opb_i = 8'(b); fire_i = f; sel_i = 2'(s); clear_i = c;
      @(posedge clk);
      if (c) begin
         for (int i = 0; i < 8; i++) m_fill[i] = 0;
         m_ptr = 0; m_acc = '0; m_vld = 1'b0;
      end else if (f) begin
         int sum = 0;
         for (int i = 0; i < 8; i++)
            if (m_fill[i]) sum += m_a[i] * m_b[i];
         m_acc = m_acc + 32'(sum);
         m_res = m_acc[s*8 +: 8];
         m_vld = 1'b1;
         for (int i = 0; i < 8; i++) m_fill[i] = 0;
         m_ptr = 0;
      end else begin
         if (p) begin
            m_a[m_ptr] = int'($signed(8'(a)));
            m_b[m_ptr] = int'($signed(8'(b)));
            m_fill[m_ptr] = 1;
            m_ptr = (m_ptr + 1) % 8;
         end
         m_vld = 1'b0;
      end
      @(negedge clk);
      check(req, res_o, res_vld_o);
   endtask

   task automatic push(string req, int a, int b); step(req, 1, a, b, 0, 0, 0); endtask
   task automatic fire(string req, int s);        step(req, 0, 0, 0, 1, s, 0); endtask
   task automatic idle(string req);               step(req, 0, 0, 0, 0, 0, 0); endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      check("R1", res_o, res_vld_o);
      rst_n = 1'b1;
      idle("R1");

      // R2 R3 R4: signed products, all bytes of one sum
      push("R2", 3, 4); push("R2", -5, 6); push("R2", 127, 127); push("R2", -128, -128);
      fire("R3", 0);
      idle("R10"); idle("R10");
      fire("R4", 1); fire("R4", 2); fire("R4", 3);
      // R3 negative sum wraps the accumulator
      clear_i = 0;
      step("R7", 0, 0, 0, 1, 0, 1);
      push("R3", -100, 120); push("R3", 90, -127);
      fire("R3", 0); fire("R3", 3); fire("R3", 2);
      // R9: accumulate across fires
      push("R9", 50, 50); fire("R9", 0); push("R9", 50, 50); fire("R9", 1);
      // R5: nine pushes, slot 0 overwritten
      step("R7", 0, 0, 0, 0, 0, 1);
      for (int i = 1; i <= 9; i++) push("R5", i * 10, -i);
      fire("R5", 0); fire("R5", 1);
      // R6: empty fire adds zero
      fire("R6", 0); fire("R6", 3);
      // R8: push dropped during fire
      push("R8", 7, 7);
      step("R8", 1, 100, 100, 1, 0, 0);
      fire("R8", 0);
      // R7: clear dominates fire and push
      push("R7", 20, 20);
      step("R7", 1, 9, 9, 1, 0, 1);
      fire("R7", 0); fire("R7", 3);
      // full buffer of extremes
      for (int i = 0; i < 8; i++) push("R3", -128, -128);
      fire("R3", 0); fire("R3", 1); fire("R3", 2);
      for (int i = 0; i < 8; i++) push("R3", -128, 127);
      fire("R3", 2); fire("R3", 3);
      idle("R10");
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin repeat (5000) @(posedge clk); end
      join_any
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule